// File: doc/BRIEF.md
# Interrupt Flag and Mask Register Block

This block holds the CPU-visible registers behind three interrupt sources. The first is a periodic tick that raises a fast interrupt request. The second is a keyboard that hands over an 8-bit scan code together with a one-cycle strobe. The third is a break key whose held level becomes a non-maskable request. The CPU reaches the block over a simple byte bus. It reads a status byte that carries the timer flag in its top bit, which clears the flag. It writes a mask byte whose top bit blocks the tick. It reads the latched scan code, which acknowledges the keyboard request. It reads a break byte that mirrors the key.

A read qualifier marks an access as inspection only. Such a read returns the same data as a normal read but clears nothing, so a debugger can look at the registers without losing a pending interrupt. The asynchronous active-low reset is released through an internal two-flop synchronizer. The break-key level passes through a configurable synchronizer chain.

Byte addresses: break 0xC8, timer status 0xCA, timer mask 0xD4, keyboard 0xE0. Any other address reads 0x00.

Top module: `irq_regs_ctrl`

## Requirements
- R1: After reset, firq_o, irq_o and nmi_o are 0, the timer mask is 0, and reads of 0xCA, 0xE0 and 0xC8 return 0x00.
- R2: A read of 0xCA returns the pending timer flag in bit 7 and 0 in bits 6..0. A read of any unmapped address, or rdata_o when no read is under way, is 0x00.
- R3: A read of 0xCA with dbg_i low clears the timer flag, and firq_o is 0 from the next cycle on, unless R7 applies.
- R4: A read with dbg_i high returns normal data but changes nothing. The timer flag, firq_o, the keyboard pending flag and irq_o all keep their values.
- R5: A write to 0xD4 stores only wdata_i bit 7 as the mask. Writing bit 7 = 1 clears the timer flag, so firq_o is 0 the next cycle. Writing bit 7 = 0, with any other bits, unmasks.
- R6: A tick_i pulse while the effective mask is 0 sets the timer flag, and firq_o is 1 the next cycle. While the mask is 1, ticks are dropped. The effective mask is the value being written when a mask write happens in the same cycle.
- R7: When a tick and a clearing read of 0xCA fall in the same cycle, the read returns the old flag and the flag ends up set.
- R8: A read of 0xC8 returns 0x80 while the synchronized break key is held and 0x00 otherwise. nmi_o follows brk_key_i after SYNC_STAGES clock edges (2 by default).
- R9: key_vld_i latches key_code_i and raises irq_o the next cycle. A read of 0xE0 returns the latched code. A read of 0xE0 with dbg_i low drops irq_o the next cycle, unless a new strobe arrives in the same cycle. In that case the read returns the old code, the new code is latched, and irq_o stays 1.
- R10: Writes to any address other than 0xD4 have no effect on the flags, the mask or the latched code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle periodic timer tick |
| key_vld_i | input | 1 | Scan code available strobe |
| key_code_i | input | 8 | Scan code |
| brk_key_i | input | 1 | Break key level, asynchronous |
| sel_i | input | 1 | Bus access this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| dbg_i | input | 1 | Read has no side effects |
| rdata_o | output | 8 | Read data, valid in the access cycle |
| firq_o | output | 1 | Fast interrupt request (timer) |
| irq_o | output | 1 | Interrupt request (keyboard) |
| nmi_o | output | 1 | Non-maskable request (break key) |

## Verification
The bench targets the cycles where two events meet. One is a tick landing on a clearing read: a design that gives the clear priority loses a timer interrupt. Another is a scan-code strobe landing on a keyboard read: a wrong design drops irq_o while a fresh code is waiting. A third is a tick landing on a mask write: a design that used the old mask would raise firq_o right after it was masked. Debug reads are mixed into the random traffic, and any hidden clear shows up as a missing interrupt. Writes of 0x7F to the mask and writes to the read-only addresses catch decoders that look at the wrong bit or the wrong address.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

  // Per-cycle bus strobes produced by the address decoder.
  typedef struct packed {
    logic rd_brk;
    logic rd_tmr;
    logic rd_key;
    logic wr_mask;
    logic clr_tmr;
    logic clr_key;
  } irq_dec_t;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_regs_pkg::*;
#(
  parameter int              AW       = 8,
  parameter logic [AW-1:0]   A_BRK    = 8'hC8,
  parameter logic [AW-1:0]   A_TMR    = 8'hCA,
  parameter logic [AW-1:0]   A_MSK    = 8'hD4,
  parameter logic [AW-1:0]   A_KEY    = 8'hE0
) (
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic          dbg_i,
  output irq_dec_t      dec_o
);

  logic rd_any;
  logic wr_any;

  always_comb begin
    rd_any        = sel_i & ~wr_i;
    wr_any        = sel_i &  wr_i;
    dec_o.rd_brk  = rd_any & (addr_i == A_BRK);
    dec_o.rd_tmr  = rd_any & (addr_i == A_TMR);
    dec_o.rd_key  = rd_any & (addr_i == A_KEY);
    dec_o.wr_mask = wr_any & (addr_i == A_MSK);
    // Inspection reads return data but never acknowledge.
    dec_o.clr_tmr = dec_o.rd_tmr & ~dbg_i;
    dec_o.clr_key = dec_o.rd_key & ~dbg_i;
  end

endmodule

// File: rtl/irq_timer_flag.sv
module irq_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic wr_mask_i,
  input  logic mask_bit_i,
  input  logic clr_i,
  output logic flag_o,
  output logic mask_o
);

  logic flag_q, flag_d;
  logic mask_q, mask_d;
  logic set_c, drop_c;

  always_comb begin
    mask_d = wr_mask_i ? mask_bit_i : mask_q;
    set_c  = tick_i & ~mask_d;
    drop_c = clr_i | mask_d;
    if (set_c)       flag_d = 1'b1;
    else if (drop_c) flag_d = 1'b0;
    else             flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (wr_mask_i) mask_q <= mask_d;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;

endmodule

// File: rtl/irq_key_latch.sv
module irq_key_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [DW-1:0] code_i,
  input  logic          clr_i,
  output logic          pend_o,
  output logic [DW-1:0] code_o
);

  logic          pend_q, pend_d;
  logic [DW-1:0] code_q;

  always_comb begin
    if (vld_i)      pend_d = 1'b1;
    else if (clr_i) pend_d = 1'b0;
    else            pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      code_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (vld_i) code_q <= code_i;
    end
  end

  assign pend_o = pend_q;
  assign code_o = code_q;

endmodule

// File: rtl/irq_break_sync.sv
module irq_break_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_regs_ctrl.sv
module irq_regs_ctrl
  import irq_regs_pkg::*;
#(
  parameter int              DW          = 8,
  parameter int              AW          = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [AW-1:0]   A_BRK       = 8'hC8,
  parameter logic [AW-1:0]   A_TMR       = 8'hCA,
  parameter logic [AW-1:0]   A_MSK       = 8'hD4,
  parameter logic [AW-1:0]   A_KEY       = 8'hE0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          key_vld_i,
  input  logic [DW-1:0] key_code_i,
  input  logic          brk_key_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          dbg_i,
  output logic [DW-1:0] rdata_o,
  output logic          firq_o,
  output logic          irq_o,
  output logic          nmi_o
);

  localparam int MSB = DW - 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  irq_dec_t      dec;
  logic          tmr_flag;
  logic          tmr_mask;
  logic          key_pend;
  logic [DW-1:0] key_code;
  logic          brk_s;

  irq_bus_decode #(
    .AW(AW), .A_BRK(A_BRK), .A_TMR(A_TMR), .A_MSK(A_MSK), .A_KEY(A_KEY)
  ) u_dec (
    .sel_i (sel_i),
    .wr_i  (wr_i),
    .addr_i(addr_i),
    .dbg_i (dbg_i),
    .dec_o (dec)
  );

  irq_timer_flag u_tmr (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick_i    (tick_i),
    .wr_mask_i (dec.wr_mask),
    .mask_bit_i(wdata_i[MSB]),
    .clr_i     (dec.clr_tmr),
    .flag_o    (tmr_flag),
    .mask_o    (tmr_mask)
  );

  irq_key_latch #(.DW(DW)) u_key (
    .clk   (clk),
    .rst_n (rst_n_s),
    .vld_i (key_vld_i),
    .code_i(key_code_i),
    .clr_i (dec.clr_key),
    .pend_o(key_pend),
    .code_o(key_code)
  );

  irq_break_sync #(.STAGES(SYNC_STAGES)) u_brk (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .async_i(brk_key_i),
    .sync_o (brk_s)
  );

  always_comb begin
    rdata_o = '0;
    if (dec.rd_tmr)      rdata_o[MSB] = tmr_flag;
    else if (dec.rd_brk) rdata_o[MSB] = brk_s;
    else if (dec.rd_key) rdata_o      = key_code;
  end

  assign firq_o = tmr_flag;
  assign irq_o  = key_pend;
  assign nmi_o  = brk_s;

endmodule

// File: rtl/irq_regs_chk.sv
module irq_regs_chk #(
  parameter int              DW    = 8,
  parameter int              AW    = 8,
  parameter logic [AW-1:0]   A_BRK = 8'hC8,
  parameter logic [AW-1:0]   A_TMR = 8'hCA,
  parameter logic [AW-1:0]   A_MSK = 8'hD4,
  parameter logic [AW-1:0]   A_KEY = 8'hE0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          key_vld_i,
  input logic          sel_i,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          dbg_i,
  input logic [DW-1:0] rdata_o,
  input logic          firq_o,
  input logic          irq_o,
  input logic          nmi_o,
  input logic          tmr_mask
);

  logic rd_t, rd_k, rd_b, wm, wm1, eff_mask;
  assign rd_t     = sel_i && !wr_i && addr_i == A_TMR;
  assign rd_k     = sel_i && !wr_i && addr_i == A_KEY;
  assign rd_b     = sel_i && !wr_i && addr_i == A_BRK;
  assign wm       = sel_i && wr_i && addr_i == A_MSK;
  assign wm1      = wm && wdata_i[DW-1];
  assign eff_mask = wm ? wdata_i[DW-1] : tmr_mask;

  a_r6_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !eff_mask |=> firq_o);

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_t && !dbg_i && !tick_i |=> !firq_o);

  a_r4_dbg_keeps_firq: assert property (@(posedge clk) disable iff (!rst_n)
    rd_t && dbg_i && firq_o |=> firq_o);

  a_r4_dbg_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rd_k && dbg_i && irq_o |=> irq_o);

  a_r5_mask_drops: assert property (@(posedge clk) disable iff (!rst_n)
    wm1 |=> !firq_o);

  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_mask && !wm && !firq_o |=> !firq_o);

  a_r9_key_sets: assert property (@(posedge clk) disable iff (!rst_n)
    key_vld_i |=> irq_o);

  a_r9_key_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rd_k && !dbg_i && !key_vld_i |=> !irq_o);

  a_r2_status_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_t |-> rdata_o[DW-2:0] == '0);

  a_r8_break_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b |-> rdata_o == {nmi_o, {(DW-1){1'b0}}});

endmodule

bind irq_regs_ctrl irq_regs_chk #(
  .DW(DW), .AW(AW), .A_BRK(A_BRK), .A_TMR(A_TMR), .A_MSK(A_MSK), .A_KEY(A_KEY)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .tick_i   (tick_i),
  .key_vld_i(key_vld_i),
  .sel_i    (sel_i),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .dbg_i    (dbg_i),
  .rdata_o  (rdata_o),
  .firq_o   (firq_o),
  .irq_o    (irq_o),
  .nmi_o    (nmi_o),
  .tmr_mask (tmr_mask)
);

// File: tb/test_irq_regs_ctrl.sv
module test_irq_regs_ctrl;

  localparam real  CLK_NS = 8.0;
  localparam int   SYNC   = 2;
  localparam logic [7:0] A_BRK = 8'hC8, A_TMR = 8'hCA, A_MSK = 8'hD4, A_KEY = 8'hE0;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i, key_vld_i, brk_key_i, sel_i, wr_i, dbg_i;
  logic [7:0] key_code_i, addr_i, wdata_i, rdata_o;
  logic       firq_o, irq_o, nmi_o;

  int checks   = 0;
  int failures = 0;

  // bench model
  logic       m_flag, m_mask, m_pend;
  logic [7:0] m_code;

  always #(CLK_NS/2) clk = ~clk;

  irq_regs_ctrl #(.SYNC_STAGES(SYNC)) i_irq_regs_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .key_vld_i(key_vld_i),
    .key_code_i(key_code_i), .brk_key_i(brk_key_i), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .dbg_i(dbg_i), .rdata_o(rdata_o),
    .firq_o(firq_o), .irq_o(irq_o), .nmi_o(nmi_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic s, input logic w, input logic [7:0] a);
    if (!s || w)     return 8'h00;
    if (a == A_TMR)  return {m_flag, 7'b0};
    if (a == A_KEY)  return m_code;
    if (a == A_BRK)  return {nmi_o, 7'b0};
    return 8'h00;
  endfunction

  task automatic model_step(input logic s, input logic w, input logic [7:0] a,
                            input logic [7:0] wd, input logic d, input logic tk,
                            input logic kv, input logic [7:0] kc);
    logic mn;
    mn = (s && w && a == A_MSK) ? wd[7] : m_mask;
    if (tk && !mn)                                m_flag = 1'b1;
    else if (mn || (s && !w && a == A_TMR && !d)) m_flag = 1'b0;
    m_mask = mn;
    if (kv) begin m_pend = 1'b1; m_code = kc; end
    else if (s && !w && a == A_KEY && !d) m_pend = 1'b0;
  endtask

  // Drive one cycle from just after a falling edge; sample read data mid-cycle;
  // return at the next falling edge with inputs idle.
  task automatic cyc(input logic s, input logic w, input logic [7:0] a,
                     input logic [7:0] wd, input logic d, input logic tk,
                     input logic kv, input logic [7:0] kc, output logic [7:0] rd);
    sel_i = s; wr_i = w; addr_i = a; wdata_i = wd; dbg_i = d;
    tick_i = tk; key_vld_i = kv; key_code_i = kc;
    #2;
    rd = rdata_o;
    model_step(s, w, a, wd, d, tk, kv, kc);
    @(negedge clk);
    sel_i = 0; wr_i = 0; addr_i = 0; wdata_i = 0; dbg_i = 0;
    tick_i = 0; key_vld_i = 0; key_code_i = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic d, output logic [7:0] rd);
    cyc(1, 0, a, 8'h00, d, 0, 0, 8'h00, rd);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] wd);
    logic [7:0] r;
    cyc(1, 1, a, wd, 0, 0, 0, 8'h00, r);
  endtask

  task automatic idle(input logic tk);
    logic [7:0] r;
    cyc(0, 0, 8'h00, 8'h00, 0, tk, 0, 8'h00, r);
  endtask

  initial begin
    #(CLK_NS * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd2024));
    sel_i = 0; wr_i = 0; addr_i = 0; wdata_i = 0; dbg_i = 0;
    tick_i = 0; key_vld_i = 0; key_code_i = 0; brk_key_i = 0;
    m_flag = 0; m_mask = 0; m_pend = 0; m_code = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 firq", {7'b0, firq_o}, 8'h00);
    chk("R1 irq",  {7'b0, irq_o},  8'h00);
    chk("R1 nmi",  {7'b0, nmi_o},  8'h00);
    rd_reg(A_TMR, 1, r); chk("R1 tmr read", r, 8'h00);
    rd_reg(A_KEY, 1, r); chk("R1 key read", r, 8'h00);
    rd_reg(A_BRK, 0, r); chk("R1 brk read", r, 8'h00);
    idle(1); chk("R1 mask clear, tick sets firq", {7'b0, firq_o}, 8'h01);

    // R4 inspection read, R2 format, R3 clear
    rd_reg(A_TMR, 1, r); chk("R2 status byte", r, 8'h80);
    chk("R4 dbg keeps firq", {7'b0, firq_o}, 8'h01);
    rd_reg(A_TMR, 0, r); chk("R3 read returns flag", r, 8'h80);
    chk("R3 firq cleared", {7'b0, firq_o}, 8'h00);
    rd_reg(A_TMR, 0, r); chk("R3 flag gone", r, 8'h00);

    // R5 only bit 7 of the mask
    wr_reg(A_MSK, 8'h7F); idle(1);
    chk("R5 low bits do not mask", {7'b0, firq_o}, 8'h01);
    wr_reg(A_MSK, 8'h80);
    chk("R5 mask drops firq", {7'b0, firq_o}, 8'h00);
    idle(1); chk("R6 masked tick dropped", {7'b0, firq_o}, 8'h00);
    cyc(1, 1, A_MSK, 8'h00, 0, 1, 0, 8'h00, r);
    chk("R6 tick with unmask write", {7'b0, firq_o}, 8'h01);
    cyc(1, 1, A_MSK, 8'hFF, 0, 1, 0, 8'h00, r);
    chk("R6 tick with mask write", {7'b0, firq_o}, 8'h00);
    wr_reg(A_MSK, 8'h00);

    // R7 tick coincides with clearing read
    idle(1);
    cyc(1, 0, A_TMR, 8'h00, 0, 1, 0, 8'h00, r);
    chk("R7 read returns old flag", r, 8'h80);
    chk("R7 flag stays set", {7'b0, firq_o}, 8'h01);

    // R10 writes elsewhere are ignored
    wr_reg(A_TMR, 8'h00);
    chk("R10 write to status ignored", {7'b0, firq_o}, 8'h01);
    cyc(0, 0, 8'h00, 8'h00, 0, 0, 1, 8'h5A, r);
    chk("R9 strobe raises irq", {7'b0, irq_o}, 8'h01);
    wr_reg(A_KEY, 8'hFF);
    wr_reg(8'hC9, 8'hFF);
    idle(1); chk("R10 foreign write leaves mask open", {7'b0, firq_o}, 8'h01);
    rd_reg(A_KEY, 1, r); chk("R10 code kept after write", r, 8'h5A);
    chk("R4 dbg keeps irq", {7'b0, irq_o}, 8'h01);
    rd_reg(8'hC9, 0, r); chk("R2 unmapped read", r, 8'h00);

    // R9 keyboard ack and strobe collision
    rd_reg(A_KEY, 0, r); chk("R9 code read", r, 8'h5A);
    chk("R9 read drops irq", {7'b0, irq_o}, 8'h00);
    cyc(0, 0, 8'h00, 8'h00, 0, 0, 1, 8'h11, r);
    cyc(1, 0, A_KEY, 8'h00, 0, 0, 1, 8'h22, r);
    chk("R9 collision returns old code", r, 8'h11);
    chk("R9 collision keeps irq", {7'b0, irq_o}, 8'h01);
    rd_reg(A_KEY, 0, r); chk("R9 new code latched", r, 8'h22);

    // R8 break key
    brk_key_i = 1;
    idle(0); chk("R8 nmi not yet", {7'b0, nmi_o}, 8'h00);
    idle(0); chk("R8 nmi after sync", {7'b0, nmi_o}, 8'h01);
    rd_reg(A_BRK, 0, r); chk("R8 break held", r, 8'h80);
    brk_key_i = 0;
    repeat (SYNC) idle(0);
    rd_reg(A_BRK, 0, r); chk("R8 break released", r, 8'h00);
    chk("R8 nmi low", {7'b0, nmi_o}, 8'h00);

    // Random traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic s, w, d, tk, kv;
      logic [7:0] a, wd, kc, e;
      int op;
      op = $urandom % 6;
      s  = (op != 0);
      w  = (op == 2 || op == 5);
      case (op)
        1, 2:    a = A_TMR;
        3:       a = A_KEY;
        4:       a = (($urandom % 2) == 0) ? A_BRK : 8'hC9;
        default: a = A_MSK;
      endcase
      wd = 8'($urandom);
      if (op == 5) wd[7] = (($urandom % 4) == 0);
      d  = (($urandom % 3) == 0);
      tk = (($urandom % 3) == 0);
      kv = (($urandom % 4) == 0);
      kc = 8'($urandom);
      e  = exp_rd(s, w, a);
      cyc(s, w, a, wd, d, tk, kv, kc, r);
      chk("R2/R9 random read", r, e);
      chk("R3/R6 random firq", {7'b0, firq_o}, {7'b0, m_flag});
      chk("R9 random irq", {7'b0, irq_o}, {7'b0, m_pend});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule